// File: doc/BRIEF.md
# Memory-Type Resolving Translation Cache

This block is a small, fully associative translation cache whose entries carry a physical page number and a memory type that is resolved once, when the entry is written. During a fill, the physical page is matched against a set of programmable base/mask range registers. The type those ranges give is merged with the attribute that arrives with the page, and the merged type is stored in the entry. A lookup then reads the type straight from the hitting entry. The range registers never sit in the lookup path.

Because the stored types depend on the range registers, any write to the range-register port empties the whole cache, global entries included. A separate invalidate input clears only the entries that are not marked global. Replacement is round-robin over the entries. A fill whose virtual page is already present overwrites that entry in place. Lookups answer one cycle after they are presented, with a hit or a one-cycle miss pulse.

Top module: `mtx_xlat_top`

## Requirements
- R1: After reset no entry is valid, every lookup misses, and `lkPpn`/`lkType` read 0.
- R2: Type codes are UC=0, WC=1, WT=2, WP=3, WB=4, and codes 5 to 7 count as UC. Two types merge to the more restrictive one, in the order UC, WC, WT, WP, WB, which is the lower code. The stored type is the merge of the range type and `fillAttr`.
- R3: An enabled range matches a page when `(page & mask) == (base & mask)`. All matching ranges are merged by the R2 rule. If no range matches, the default type is used. After reset the default type is UC and all ranges are disabled. `cfgField` 0 writes the base and type of range `cfgIdx`, 1 writes its mask and enable, 2 writes the default type, and 3 changes no register.
- R4: A lookup presented in cycle N gives `lkHit` or `lkMiss` (never both) in cycle N+1, with the entry's page and type on a hit and 0 on a miss. With no lookup presented, all four lookup outputs are 0 in the next cycle, so a miss lasts exactly one cycle.
- R5: Any cycle with `cfgWe` high, whatever the field, invalidates every entry, including global ones.
- R6: `invNonGlobal` invalidates non-global entries and leaves global entries valid.
- R7: A fill for a new virtual page goes to the entry chosen by a round-robin pointer. The pointer starts at 0, advances by one per such fill and wraps after the last entry. A flush does not move it.
- R8: A fill whose virtual page matches a valid entry rewrites that entry and does not advance the pointer.
- R9: A fill in the same cycle as a range-register write is discarded.
- R10: A lookup in the same cycle as a fill sees the contents from before the fill. A fill in the same cycle as `invNonGlobal` survives the invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Range-register write strobe (always flushes) |
| cfgIdx | input | 2 | Range register selected |
| cfgField | input | 2 | 0 base+type, 1 mask+enable, 2 default type, 3 none |
| cfgPage | input | 24 | Base or mask page bits |
| cfgType | input | 3 | Range type or default type |
| cfgEn | input | 1 | Range enable (field 1) |
| fillValid | input | 1 | Fill request |
| fillVpn | input | 20 | Virtual page to fill |
| fillPpn | input | 24 | Physical page of the fill |
| fillAttr | input | 3 | Page attribute type |
| fillGlobal | input | 1 | Entry survives non-global invalidate |
| invNonGlobal | input | 1 | Invalidate non-global entries |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | 20 | Virtual page looked up |
| lkHit | output | 1 | Lookup hit (one cycle later) |
| lkMiss | output | 1 | Lookup miss pulse (one cycle later) |
| lkPpn | output | 24 | Physical page on hit, else 0 |
| lkType | output | 3 | Stored memory type on hit, else 0 |

## Verification
Two pairs of operations can land in the same cycle. The first is a fill together with a range-register write: the bench drives both in one cycle, and a later lookup of that page must miss, because the fill was resolved against ranges that were just replaced. The second is a lookup together with a fill of the same page: the lookup must miss and a lookup in the following cycle must hit. A fill together with `invNonGlobal` is also driven, and the new non-global entry must still hit afterwards. Expected results come from a bench model of the entries and the pointer, and every step compares all lookup outputs.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  localparam int TYPE_W = 3;

  localparam logic [TYPE_W-1:0] MT_UC = 3'd0;
  localparam logic [TYPE_W-1:0] MT_WC = 3'd1;
  localparam logic [TYPE_W-1:0] MT_WT = 3'd2;
  localparam logic [TYPE_W-1:0] MT_WP = 3'd3;
  localparam logic [TYPE_W-1:0] MT_WB = 3'd4;

  localparam logic [1:0] CFG_BASE    = 2'd0;
  localparam logic [1:0] CFG_MASK    = 2'd1;
  localparam logic [1:0] CFG_DEFAULT = 2'd2;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic flushAll;
    logic flushLocal;
    logic fillWr;
  } ctrlStrobe_t;

  // codes above write-back are not defined: treat them as uncacheable
  function automatic logic [TYPE_W-1:0] legalType(input logic [TYPE_W-1:0] t);
    return (t > MT_WB) ? MT_UC : t;
  endfunction

  // lower code is more restrictive, so the merge keeps the lower legal code
  function automatic logic [TYPE_W-1:0] mergeType(input logic [TYPE_W-1:0] a,
                                                  input logic [TYPE_W-1:0] b);
    logic [TYPE_W-1:0] la;
    logic [TYPE_W-1:0] lb;
    la = legalType(a);
    lb = legalType(b);
    return (la < lb) ? la : lb;
  endfunction

endpackage

// File: rtl/mtx_range_file.sv
module mtx_range_file
  import mtx_pkg::*;
#(
  parameter int RANGES = 4,
  parameter int PPN_W  = 24,
  parameter int RIDX_W = $clog2(RANGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [RIDX_W-1:0] cfgIdx,
  input  logic [1:0]        cfgField,
  input  logic [PPN_W-1:0]  cfgPage,
  input  logic [TYPE_W-1:0] cfgType,
  input  logic              cfgEn,
  input  logic [PPN_W-1:0]  probePpn,
  output logic [TYPE_W-1:0] rangeType
);

  logic [PPN_W-1:0]  baseReg [RANGES];
  logic [PPN_W-1:0]  maskReg [RANGES];
  logic [TYPE_W-1:0] typeReg [RANGES];
  logic [RANGES-1:0] enReg;
  logic [RANGES-1:0] matchVec;
  logic [TYPE_W-1:0] defType;

  for (genvar r = 0; r < RANGES; r++) begin : g_range
    logic selThis;
    assign selThis = cfgWe && (cfgIdx == RIDX_W'(r));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseReg[r] <= '0;
        maskReg[r] <= '0;
        typeReg[r] <= MT_UC;
        enReg[r]   <= 1'b0;
      end else if (selThis) begin
        if (cfgField == CFG_BASE) begin
          baseReg[r] <= cfgPage;
          typeReg[r] <= cfgType;
        end else if (cfgField == CFG_MASK) begin
          maskReg[r] <= cfgPage;
          enReg[r]   <= cfgEn;
        end
      end
    end

    assign matchVec[r] = enReg[r] &&
                         ((probePpn & maskReg[r]) == (baseReg[r] & maskReg[r]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      defType <= MT_UC;
    end else if (cfgWe && (cfgField == CFG_DEFAULT)) begin
      defType <= cfgType;
    end
  end

  always_comb begin
    logic [TYPE_W-1:0] acc;
    acc = MT_WB;
    for (int r = 0; r < RANGES; r++) begin
      if (matchVec[r]) acc = mergeType(acc, typeReg[r]);
    end
    rangeType = (|matchVec) ? acc : legalType(defType);
  end

endmodule

// File: rtl/mtx_entry_array.sv
module mtx_entry_array
  import mtx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 24,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [TYPE_W-1:0] fillType,
  input  logic              fillGlobal,
  output logic              fillHitAny,
  output logic [IDX_W-1:0]  fillHitIdx,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic              lkHit,
  output logic              lkMiss,
  output logic [PPN_W-1:0]  lkPpn,
  output logic [TYPE_W-1:0] lkType
);

  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] globVec;
  logic [VPN_W-1:0]   eVpn  [ENTRIES];
  logic [PPN_W-1:0]   ePpn  [ENTRIES];
  logic [TYPE_W-1:0]  eType [ENTRIES];
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] fillMatch;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic writeThis;
    assign writeThis = strobe.fillWr && (fillIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validVec[e] <= 1'b0;
        globVec[e]  <= 1'b0;
        eVpn[e]     <= '0;
        ePpn[e]     <= '0;
        eType[e]    <= MT_UC;
      end else if (strobe.flushAll) begin
        validVec[e] <= 1'b0;
      end else begin
        if (strobe.flushLocal && !globVec[e]) validVec[e] <= 1'b0;
        // a fill in the same cycle lands after the local invalidate
        if (writeThis) begin
          validVec[e] <= 1'b1;
          globVec[e]  <= fillGlobal;
          eVpn[e]     <= fillVpn;
          ePpn[e]     <= fillPpn;
          eType[e]    <= fillType;
        end
      end
    end

    assign lkMatch[e]   = validVec[e] && (eVpn[e] == lkVpn);
    assign fillMatch[e] = validVec[e] && (eVpn[e] == fillVpn);
  end

  always_comb begin
    fillHitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fillMatch[i]) fillHitIdx = IDX_W'(i);
    end
  end
  assign fillHitAny = |fillMatch;

  logic [PPN_W-1:0]  selPpn;
  logic [TYPE_W-1:0] selType;
  always_comb begin
    selPpn  = '0;
    selType = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatch[i]) begin
        selPpn  = selPpn | ePpn[i];
        selType = selType | eType[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkHit  <= 1'b0;
      lkMiss <= 1'b0;
      lkPpn  <= '0;
      lkType <= '0;
    end else begin
      lkHit  <= lkValid && (|lkMatch);
      lkMiss <= lkValid && !(|lkMatch);
      lkPpn  <= (lkValid && (|lkMatch)) ? selPpn : '0;
      lkType <= (lkValid && (|lkMatch)) ? selType : '0;
    end
  end

  // R5: a range write leaves no valid entry behind
  a_r5_flush_all: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> (validVec == '0));

  // R6: local invalidate keeps global entries and drops the rest
  a_r6_keep_global: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flushLocal && !strobe.fillWr) |=>
      ((validVec & globVec) == $past(validVec & globVec)));

  a_r6_drop_local: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flushLocal && !strobe.fillWr) |=> ((validVec & ~globVec) == '0));

  // R8: refill in place keeps virtual pages unique
  a_r8_unique_vpn: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch));

  // R4: exactly one response per lookup, none otherwise
  a_r4_one_response: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (lkHit ^ lkMiss));

  a_r4_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> (!lkHit && !lkMiss));

  // R2: a stored type is always a defined code
  a_r2_legal_type: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkType <= MT_WB));

endmodule

// File: rtl/mtx_datapath.sv
module mtx_datapath
  import mtx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int RANGES  = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 24,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int RIDX_W  = $clog2(RANGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic              cfgWe,
  input  logic [RIDX_W-1:0] cfgIdx,
  input  logic [1:0]        cfgField,
  input  logic [PPN_W-1:0]  cfgPage,
  input  logic [TYPE_W-1:0] cfgType,
  input  logic              cfgEn,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [TYPE_W-1:0] fillAttr,
  input  logic              fillGlobal,
  output logic              fillHitAny,
  output logic [IDX_W-1:0]  fillHitIdx,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic              lkHit,
  output logic              lkMiss,
  output logic [PPN_W-1:0]  lkPpn,
  output logic [TYPE_W-1:0] lkType
);

  logic [TYPE_W-1:0] rangeType;
  logic [TYPE_W-1:0] fillType;

  mtx_range_file #(
    .RANGES (RANGES),
    .PPN_W  (PPN_W),
    .RIDX_W (RIDX_W)
  ) u_ranges (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgIdx    (cfgIdx),
    .cfgField  (cfgField),
    .cfgPage   (cfgPage),
    .cfgType   (cfgType),
    .cfgEn     (cfgEn),
    .probePpn  (fillPpn),
    .rangeType (rangeType)
  );

  // resolved once here; lookups only ever see the stored result
  assign fillType = mergeType(rangeType, fillAttr);

  mtx_entry_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .IDX_W   (IDX_W)
  ) u_entries (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fillIdx    (fillIdx),
    .fillVpn    (fillVpn),
    .fillPpn    (fillPpn),
    .fillType   (fillType),
    .fillGlobal (fillGlobal),
    .fillHitAny (fillHitAny),
    .fillHitIdx (fillHitIdx),
    .lkValid    (lkValid),
    .lkVpn      (lkVpn),
    .lkHit      (lkHit),
    .lkMiss     (lkMiss),
    .lkPpn      (lkPpn),
    .lkType     (lkType)
  );

  // R2: a stored type is never looser than the page attribute
  a_r2_not_looser: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillWr |-> (fillType <= legalType(fillAttr)));

endmodule

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
  import mtx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             fillValid,
  input  logic             invNonGlobal,
  input  logic             fillHitAny,
  input  logic [IDX_W-1:0] fillHitIdx,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] fillIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic             allocNew;

  // a range write wins the cycle: a fill resolved against old ranges is dropped
  always_comb begin
    strobe.flushAll   = cfgWe;
    strobe.flushLocal = invNonGlobal && !cfgWe;
    strobe.fillWr     = fillValid && !cfgWe;
  end

  assign allocNew = strobe.fillWr && !fillHitAny;
  assign fillIdx  = fillHitAny ? fillHitIdx : rrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (allocNew) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  // R7: each new allocation moves the pointer one step with wrap
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !cfgWe && !fillHitAny) |=>
      (rrPtr == (($past(rrPtr) == LAST_IDX) ? '0 : $past(rrPtr) + 1'b1)));

  // R8 and R9: a refill in place or a dropped fill leaves the pointer alone
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!fillValid || cfgWe || fillHitAny) |=> $stable(rrPtr));

endmodule

// File: rtl/mtx_xlat_top.sv
module mtx_xlat_top
  import mtx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int RANGES  = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 24,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RIDX_W = $clog2(RANGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [RIDX_W-1:0] cfgIdx,
  input  logic [1:0]        cfgField,
  input  logic [PPN_W-1:0]  cfgPage,
  input  logic [2:0]        cfgType,
  input  logic              cfgEn,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [2:0]        fillAttr,
  input  logic              fillGlobal,
  input  logic              invNonGlobal,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic              lkHit,
  output logic              lkMiss,
  output logic [PPN_W-1:0]  lkPpn,
  output logic [2:0]        lkType
);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] fillIdx;
  logic             fillHitAny;
  logic [IDX_W-1:0] fillHitIdx;

  mtx_ctrl #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWe        (cfgWe),
    .fillValid    (fillValid),
    .invNonGlobal (invNonGlobal),
    .fillHitAny   (fillHitAny),
    .fillHitIdx   (fillHitIdx),
    .strobe       (strobe),
    .fillIdx      (fillIdx)
  );

  mtx_datapath #(
    .ENTRIES (ENTRIES),
    .RANGES  (RANGES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .IDX_W   (IDX_W),
    .RIDX_W  (RIDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fillIdx    (fillIdx),
    .cfgWe      (cfgWe),
    .cfgIdx     (cfgIdx),
    .cfgField   (cfgField),
    .cfgPage    (cfgPage),
    .cfgType    (cfgType),
    .cfgEn      (cfgEn),
    .fillVpn    (fillVpn),
    .fillPpn    (fillPpn),
    .fillAttr   (fillAttr),
    .fillGlobal (fillGlobal),
    .fillHitAny (fillHitAny),
    .fillHitIdx (fillHitIdx),
    .lkValid    (lkValid),
    .lkVpn      (lkVpn),
    .lkHit      (lkHit),
    .lkMiss     (lkMiss),
    .lkPpn      (lkPpn),
    .lkType     (lkType)
  );

endmodule

// File: tb/mtx_xlat_top_tb.sv
`timescale 1ns/1ps
module mtx_xlat_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [1:0]  cfgField = '0;
  logic [23:0] cfgPage = '0;
  logic [2:0]  cfgType = '0;
  logic        cfgEn = 1'b0;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [23:0] fillPpn = '0;
  logic [2:0]  fillAttr = '0;
  logic        fillGlobal = 1'b0;
  logic        invNonGlobal = 1'b0;
  logic        lkValid = 1'b0;
  logic [19:0] lkVpn = '0;
  logic        lkHit;
  logic        lkMiss;
  logic [23:0] lkPpn;
  logic [2:0]  lkType;

  always #4 clk = ~clk;

  mtx_xlat_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgField(cfgField),
    .cfgPage(cfgPage), .cfgType(cfgType), .cfgEn(cfgEn), .fillValid(fillValid),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillAttr(fillAttr), .fillGlobal(fillGlobal),
    .invNonGlobal(invNonGlobal), .lkValid(lkValid), .lkVpn(lkVpn), .lkHit(lkHit),
    .lkMiss(lkMiss), .lkPpn(lkPpn), .lkType(lkType)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model of the requirements
  bit          mValid [8];
  bit          mGlob  [8];
  logic [19:0] mVpn   [8];
  logic [23:0] mPpn   [8];
  logic [2:0]  mType  [8];
  int          mPtr = 0;
  logic [23:0] mBase [4];
  logic [23:0] mMask [4];
  logic [2:0]  mRt   [4];
  bit          mEn   [4];
  logic [2:0]  mDef = 3'd0;

  function automatic logic [2:0] bLegal(input logic [2:0] t);
    return (t >= 3'd5) ? 3'd0 : t;
  endfunction

  function automatic logic [2:0] bMerge(input logic [2:0] a, input logic [2:0] b);
    logic [2:0] x = bLegal(a);
    logic [2:0] y = bLegal(b);
    return (x <= y) ? x : y;
  endfunction

  function automatic logic [2:0] bResolve(input logic [23:0] p);
    logic [2:0] acc = 3'd4;
    bit any = 1'b0;
    for (int r = 0; r < 4; r++) begin
      if (mEn[r] && ((p & mMask[r]) == (mBase[r] & mMask[r]))) begin
        acc = bMerge(acc, mRt[r]);
        any = 1'b1;
      end
    end
    return any ? acc : bLegal(mDef);
  endfunction

  task automatic check(input string req, input logic [28:0] act, input logic [28:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got hit=%0b miss=%0b ppn=%06h type=%0d, expected hit=%0b miss=%0b ppn=%06h type=%0d",
               req, act[28], act[27], act[26:3], act[2:0], exp[28], exp[27], exp[26:3], exp[2:0]);
    end
  endtask

  // one clock cycle of stimulus with model update and output comparison
  task automatic step(input string req,
                      input bit lk, input logic [19:0] lv,
                      input bit fl, input logic [19:0] fv, input logic [23:0] fp,
                      input logic [2:0] fa, input bit fg,
                      input bit inv,
                      input bit cw, input logic [1:0] cf, input logic [1:0] ci,
                      input logic [23:0] cp, input logic [2:0] ct, input bit ce);
    logic [28:0] exp = '0;
    int hitAt = -1;
    if (lk) begin
      exp = {1'b0, 1'b1, 24'h0, 3'h0};
      for (int i = 0; i < 8; i++)
        if (mValid[i] && mVpn[i] == lv) exp = {1'b1, 1'b0, mPpn[i], mType[i]};
    end
    lkValid = lk; lkVpn = lv;
    fillValid = fl; fillVpn = fv; fillPpn = fp; fillAttr = fa; fillGlobal = fg;
    invNonGlobal = inv;
    cfgWe = cw; cfgField = cf; cfgIdx = ci; cfgPage = cp; cfgType = ct; cfgEn = ce;
    if (cw) begin
      for (int i = 0; i < 8; i++) mValid[i] = 1'b0;
      if (cf == 2'd0) begin mBase[ci] = cp; mRt[ci] = ct; end
      else if (cf == 2'd1) begin mMask[ci] = cp; mEn[ci] = ce; end
      else if (cf == 2'd2) mDef = ct;
    end else begin
      if (inv) for (int i = 0; i < 8; i++) if (!mGlob[i]) mValid[i] = 1'b0;
      if (fl) begin
        for (int i = 0; i < 8; i++) if (mValid[i] && mVpn[i] == fv) hitAt = i;
        if (hitAt < 0) begin hitAt = mPtr; mPtr = (mPtr + 1) % 8; end
        mValid[hitAt] = 1'b1; mGlob[hitAt] = fg; mVpn[hitAt] = fv;
        mPpn[hitAt] = fp; mType[hitAt] = bMerge(bResolve(fp), fa);
      end
    end
    @(negedge clk);
    check(req, {lkHit, lkMiss, lkPpn, lkType}, exp);
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic lookup(input string req, input logic [19:0] v);
    step(req, 1, v, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic fill(input string req, input logic [19:0] v, input logic [23:0] p,
                      input logic [2:0] a, input bit g);
    step(req, 0, 0, 1, v, p, a, g, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic cfg(input string req, input logic [1:0] f, input logic [1:0] i,
                     input logic [23:0] p, input logic [2:0] t, input bit e);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0, 1, f, i, p, t, e);
  endtask

  initial begin
    for (int r = 0; r < 4; r++) begin mBase[r] = '0; mMask[r] = '0; mRt[r] = '0; mEn[r] = 0; end
    for (int i = 0; i < 8; i++) begin
      mValid[i] = 0; mGlob[i] = 0; mVpn[i] = '0; mPpn[i] = '0; mType[i] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {lkHit, lkMiss, lkPpn, lkType}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    lookup("R1", 20'h0);
    lookup("R1", 20'h12345);
    idle("R4 quiet after miss");

    // R2: every range type against every page attribute, no range enabled (R3 default)
    for (int rt = 0; rt < 8; rt++) begin
      cfg("R3 default write", 2'd2, 2'd0, 24'h0, 3'(rt), 1'b0);
      for (int pa = 0; pa < 8; pa++) begin
        fill("R2", 20'(100 + rt * 8 + pa), 24'(24'h5000 + pa), 3'(pa), 1'b0);
        lookup("R2 merge", 20'(100 + rt * 8 + pa));
        nChecks++;
        if (lkType !== ((rt >= 5 || pa >= 5) ? 3'd0 : ((rt < pa) ? 3'(rt) : 3'(pa)))) begin
          nFails++;
          $display("FAIL R2: rt=%0d pa=%0d got type=%0d", rt, pa, lkType);
        end
      end
    end

    // R3: overlapping ranges, an undefined type code, and the default
    cfg("R3", 2'd2, 2'd0, 24'h0, 3'd4, 1'b0);
    cfg("R3", 2'd0, 2'd0, 24'h000100, 3'd2, 1'b0);
    cfg("R3", 2'd1, 2'd0, 24'hFFFF00, 3'd0, 1'b1);
    cfg("R3", 2'd0, 2'd1, 24'h000180, 3'd1, 1'b0);
    cfg("R3", 2'd1, 2'd1, 24'hFFFF80, 3'd0, 1'b1);
    cfg("R3", 2'd0, 2'd2, 24'h000400, 3'd3, 1'b0);
    cfg("R3", 2'd1, 2'd2, 24'hFFFC00, 3'd0, 1'b1);
    cfg("R3", 2'd0, 2'd3, 24'h000600, 3'd6, 1'b0);
    cfg("R3", 2'd1, 2'd3, 24'hFFFF00, 3'd0, 1'b1);
    for (int p = 0; p < 128; p++) begin
      logic [23:0] pg = 24'(p * 16);
      logic [2:0]  rx;
      if (pg >= 24'h180 && pg <= 24'h1FF)      rx = 3'd1;
      else if (pg >= 24'h100 && pg <= 24'h17F) rx = 3'd2;
      else if (pg >= 24'h600 && pg <= 24'h6FF) rx = 3'd0;
      else if (pg >= 24'h400 && pg <= 24'h7FF) rx = 3'd3;
      else                                     rx = 3'd4;
      fill("R3", 20'(20'h200 + p), pg, 3'(p % 8), 1'b0);
      lookup("R3 range sweep", 20'(20'h200 + p));
      nChecks++;
      if (lkType !== bMerge(rx, 3'(p % 8))) begin
        nFails++;
        $display("FAIL R3: page=%06h got type=%0d expected %0d", pg, lkType, bMerge(rx, 3'(p % 8)));
      end
    end

    // R7: round-robin over nine new pages
    cfg("R5 reserved field flush", 2'd3, 2'd0, 24'h0, 3'd0, 1'b0);
    for (int v = 0; v < 9; v++) fill("R7", 20'(20'h300 + v), 24'(24'h000100 + v * 8), 3'd4, 1'b0);
    for (int v = 0; v < 9; v++) lookup("R7 round robin", 20'(20'h300 + v));

    // R8: refill of a present page rewrites in place
    fill("R8", 20'h305, 24'h000720, 3'd2, 1'b0);
    for (int v = 1; v < 9; v++) lookup("R8 in place", 20'(20'h300 + v));
    fill("R8", 20'h309, 24'h000050, 3'd4, 1'b0);
    for (int v = 1; v < 10; v++) lookup("R8 pointer held", 20'(20'h300 + v));

    // R5: global entries also flushed, by a base write
    fill("R5", 20'h3A0, 24'h000440, 3'd4, 1'b1);
    lookup("R5 before", 20'h3A0);
    cfg("R5 base write flush", 2'd0, 2'd3, 24'h000600, 3'd6, 1'b0);
    lookup("R5 global flushed", 20'h3A0);

    // R6: local invalidate
    for (int v = 0; v < 8; v++) fill("R6", 20'(20'h400 + v), 24'(24'h000010 * v), 3'(v % 5), v < 4);
    step("R6 invalidate", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    for (int v = 0; v < 8; v++) lookup("R6 global kept, local gone", 20'(20'h400 + v));

    // R9: fill together with a range write is dropped
    step("R9 fill with cfg", 0, 0, 1, 20'h4F0, 24'h000400, 3'd4, 1'b1, 0, 1, 2'd3, 0, 0, 0, 0);
    lookup("R9 dropped fill", 20'h4F0);
    fill("R9", 20'h4F1, 24'h000180, 3'd4, 1'b0);
    lookup("R9 pointer unmoved", 20'h4F1);

    // R10: lookup with fill of the same page, and fill with local invalidate
    step("R10 lookup with fill", 1, 20'h500, 1, 20'h500, 24'h000404, 3'd4, 1'b0, 0, 0, 0, 0, 0, 0, 0);
    lookup("R10 hit after fill", 20'h500);
    step("R10 fill with invalidate", 0, 0, 1, 20'h501, 24'h000108, 3'd3, 1'b0, 1, 0, 0, 0, 0, 0, 0);
    lookup("R10 fill survives", 20'h501);
    lookup("R10 older local gone", 20'h500);
    idle("R4 quiet");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule